// File: doc/BRIEF.md
# I2C Slave Event Dispatcher

This block tracks the slave side of an I2C controller. The bit-level bus engine hands it one status word per bus event. The word carries a set of flags: bus error, stop seen, no-acknowledge, new address match, data attention, and transfer direction. It also says which kind of match occurred, and it carries the received byte. The dispatcher keeps a small state (idle, slave-transmit, slave-receive) and turns each status word into at most one event on a compact user-side stream. Each event is a code plus an 8-bit payload.

The user side answers transmit-byte requests with a byte. In slave-transmit the block passes that byte on to the controller one cycle later. An inactivity timer runs in both slave states. If the bus goes quiet too long, the block reports a timeout error and falls back to idle. The timeout length is a count of milliseconds times a count of clock cycles per millisecond.

Top module: `i2c_slave_dispatch`

## Requirements
- R1: After reset the state output is idle (state encoding: 0 idle, 1 slave-transmit, 2 slave-receive), no event is valid and no transmit byte is forwarded.
- R2: A status word with the bus-error flag, in any state, emits an error event (code 7, payload 1) and leaves the block idle; this flag outranks every other flag.
- R3: On a match with the own-address flag set, the block enters slave-transmit if the direction flag is 1 and slave-receive if it is 0, and emits a start event (code 1) whose payload is the 7-bit own address in bits 7:1 and the direction in bit 0.
- R4: On a match with only the general-call flag set, the block enters slave-receive and emits a general-call event (code 2, payload 0); the own-address flag wins when both are set.
- R5: A match with neither the own-address flag nor the general-call flag emits an error event (code 7, payload 2) and goes idle.
- R6: A match that arrives while in slave-transmit or slave-receive is a repeated start and is dispatched again as in R3, R4 and R5.
- R7: In a slave state, the stop flag emits a stop event (code 6) and goes idle; it outranks no-acknowledge, match and data.
- R8: In slave-transmit, the no-acknowledge flag emits a no-ack event (code 5) and keeps the state; in slave-receive that flag is ignored.
- R9: In a slave state with data attention set, slave-transmit emits a transmit-request event (code 4, payload 0) and slave-receive emits a receive event (code 3) carrying the received byte; a status word in a slave state with none of stop, match or data attention (and no applicable no-ack) emits an error event (code 7, payload 2) and goes idle.
- R10: In idle, a status word without bus error or match emits no event and leaves the state idle.
- R11: In a slave state, if no status word arrives for TIMEOUT_MS*CYCLES_PER_MS cycles, the block emits an error event (code 7, payload 3) and goes idle; every status word restarts the count.
- R12: A user transmit byte offered while the state is slave-transmit appears on the controller-side transmit port one cycle later; in any other state it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A status word is present this cycle |
| evt_buserr | input | 1 | Bus error flag |
| evt_stop | input | 1 | Stop condition seen while addressed |
| evt_nack | input | 1 | Master did not acknowledge |
| evt_match | input | 1 | New address match (start or repeated start) |
| evt_data | input | 1 | Data attention: byte received or byte wanted |
| evt_dir | input | 1 | Direction of the match, 1 = slave transmits |
| evt_own | input | 1 | Match was on the own address |
| evt_gcall | input | 1 | Match was on the general-call address |
| evt_rx_byte | input | 8 | Byte received from the bus |
| usr_tx_valid | input | 1 | User offers a transmit byte |
| usr_tx_byte | input | 8 | User transmit byte |
| ev_valid | output | 1 | User event valid |
| ev_code | output | 3 | Event code |
| ev_data | output | 8 | Event payload |
| ctl_tx_valid | output | 1 | Transmit byte for the controller is valid |
| ctl_tx_byte | output | 8 | Transmit byte for the controller |
| slave_state | output | 2 | Current state |

## Verification
The bench aims at flag combinations that test priority. A bus error mixed with a stop must report an error, not a stop; a design with the priority inverted would emit the stop event instead. A stop mixed with a match must end the transfer; a design that checked the match first would report a spurious start. A match that names both the own address and the general call must yield a start event, and a design with the wrong order would report a general call with payload zero. Repeated starts that flip direction check that the re-dispatch changes state. A timer that was not restarted by a received byte would fire several cycles early, and that is checked as well. Transmit bytes offered while idle or receiving must never reach the controller side.

// File: rtl/i2c_sd_pkg.sv
package i2c_sd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STX  = 2'd1,
        ST_SRX  = 2'd2
    } sd_state_e;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_START = 3'd1,
        EV_GCALL = 3'd2,
        EV_RXB   = 3'd3,
        EV_TXREQ = 3'd4,
        EV_NACK  = 3'd5,
        EV_STOP  = 3'd6,
        EV_ERR   = 3'd7
    } sd_code_e;

    localparam logic [7:0] ERR_BUS     = 8'd1;
    localparam logic [7:0] ERR_STATUS  = 8'd2;
    localparam logic [7:0] ERR_TIMEOUT = 8'd3;

    typedef struct packed {
        logic       buserr;
        logic       stop;
        logic       nack;
        logic       match;
        logic       data;
        logic       dir;
        logic       own;
        logic       gcall;
        logic [7:0] rx_byte;
    } sd_status_t;

    typedef struct packed {
        logic       fire;
        sd_code_e   code;
        logic [7:0] data;
        sd_state_e  nxt;
    } sd_action_t;

endpackage

// File: rtl/i2c_sd_timer.sv
module i2c_sd_timer #(
    parameter int unsigned TMO_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int unsigned CW = $clog2(TMO_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && !restart && (cnt_q == CW'(TMO_CYCLES - 1));
        if (!run || restart || expire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(TMO_CYCLES));

    assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);

endmodule

// File: rtl/i2c_sd_classify.sv
module i2c_sd_classify
    import i2c_sd_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h2A
) (
    input  sd_state_e  state,
    input  sd_status_t st,
    output sd_action_t act
);
    sd_action_t match_act;

    always_comb begin
        match_act = '0;
        match_act.fire = 1'b1;
        if (st.own) begin
            match_act.code = EV_START;
            match_act.data = {OWN_ADDR, st.dir};
            match_act.nxt  = st.dir ? ST_STX : ST_SRX;
        end else if (st.gcall) begin
            match_act.code = EV_GCALL;
            match_act.data = 8'h00;
            match_act.nxt  = ST_SRX;
        end else begin
            match_act.code = EV_ERR;
            match_act.data = ERR_STATUS;
            match_act.nxt  = ST_IDLE;
        end
    end

    always_comb begin
        act      = '0;
        act.nxt  = state;
        if (st.buserr) begin
            act.fire = 1'b1;
            act.code = EV_ERR;
            act.data = ERR_BUS;
            act.nxt  = ST_IDLE;
        end else if (state == ST_IDLE) begin
            if (st.match) begin
                act = match_act;
            end
        end else if (st.stop) begin
            act.fire = 1'b1;
            act.code = EV_STOP;
            act.nxt  = ST_IDLE;
        end else if (st.nack && state == ST_STX) begin
            act.fire = 1'b1;
            act.code = EV_NACK;
        end else if (st.match) begin
            act = match_act;
        end else if (st.data) begin
            act.fire = 1'b1;
            if (state == ST_STX) begin
                act.code = EV_TXREQ;
            end else begin
                act.code = EV_RXB;
                act.data = st.rx_byte;
            end
        end else begin
            act.fire = 1'b1;
            act.code = EV_ERR;
            act.data = ERR_STATUS;
            act.nxt  = ST_IDLE;
        end
    end

endmodule

// File: rtl/i2c_slave_dispatch.sv
module i2c_slave_dispatch
    import i2c_sd_pkg::*;
#(
    parameter logic [6:0]  OWN_ADDR      = 7'h2A,
    parameter int unsigned TIMEOUT_MS    = 35,
    parameter int unsigned CYCLES_PER_MS = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_valid,
    input  logic       evt_buserr,
    input  logic       evt_stop,
    input  logic       evt_nack,
    input  logic       evt_match,
    input  logic       evt_data,
    input  logic       evt_dir,
    input  logic       evt_own,
    input  logic       evt_gcall,
    input  logic [7:0] evt_rx_byte,
    input  logic       usr_tx_valid,
    input  logic [7:0] usr_tx_byte,
    output logic       ev_valid,
    output logic [2:0] ev_code,
    output logic [7:0] ev_data,
    output logic       ctl_tx_valid,
    output logic [7:0] ctl_tx_byte,
    output logic [1:0] slave_state
);
    localparam int unsigned TMO_CYCLES = TIMEOUT_MS * CYCLES_PER_MS;

    typedef struct packed {
        sd_state_e  state;
        logic       ev_valid;
        sd_code_e   ev_code;
        logic [7:0] ev_data;
        logic       tx_valid;
        logic [7:0] tx_byte;
    } regs_t;

    regs_t      r_d, r_q;
    sd_status_t st;
    sd_action_t act;
    logic       tmo_expire;

    assign st = '{buserr: evt_buserr, stop: evt_stop, nack: evt_nack,
                  match: evt_match, data: evt_data, dir: evt_dir,
                  own: evt_own, gcall: evt_gcall, rx_byte: evt_rx_byte};

    i2c_sd_classify #(.OWN_ADDR(OWN_ADDR)) u_classify (
        .state (r_q.state),
        .st    (st),
        .act   (act)
    );

    i2c_sd_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.state != ST_IDLE),
        .restart (evt_valid),
        .expire  (tmo_expire)
    );

    always_comb begin
        r_d          = r_q;
        r_d.ev_valid = 1'b0;
        r_d.ev_code  = EV_NONE;
        r_d.ev_data  = 8'h00;
        r_d.tx_valid = 1'b0;
        if (evt_valid) begin
            r_d.ev_valid = act.fire;
            r_d.ev_code  = act.fire ? act.code : EV_NONE;
            r_d.ev_data  = act.fire ? act.data : 8'h00;
            r_d.state    = act.nxt;
        end else if (tmo_expire) begin
            r_d.ev_valid = 1'b1;
            r_d.ev_code  = EV_ERR;
            r_d.ev_data  = ERR_TIMEOUT;
            r_d.state    = ST_IDLE;
        end
        if (usr_tx_valid && r_q.state == ST_STX) begin
            r_d.tx_valid = 1'b1;
            r_d.tx_byte  = usr_tx_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, ev_valid: 1'b0, ev_code: EV_NONE,
                     ev_data: 8'h00, tx_valid: 1'b0, tx_byte: 8'h00};
        end else begin
            r_q <= r_d;
        end
    end

    assign ev_valid     = r_q.ev_valid;
    assign ev_code      = r_q.ev_code;
    assign ev_data      = r_q.ev_data;
    assign ctl_tx_valid = r_q.tx_valid;
    assign ctl_tx_byte  = r_q.tx_byte;
    assign slave_state  = r_q.state;

    assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ev_valid && r_q.ev_code == EV_ERR) |-> r_q.state == ST_IDLE);

    assert_start_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ev_valid && r_q.ev_code == EV_START) |->
        r_q.state == (r_q.ev_data[0] ? ST_STX : ST_SRX));

    assert_gcall_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ev_valid && r_q.ev_code == EV_GCALL) |->
        (r_q.state == ST_SRX && r_q.ev_data == 8'h00));

    assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ev_valid && r_q.ev_code == EV_STOP) |-> r_q.state == ST_IDLE);

    assert_nack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_buserr && !evt_stop && evt_nack && r_q.state == ST_STX)
        |=> (r_q.state == ST_STX && r_q.ev_code == EV_NACK));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !(evt_valid && (evt_buserr || evt_match)))
        |=> !r_q.ev_valid);

    assert_tx_fwd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_tx_valid && r_q.state != ST_STX) |=> !r_q.tx_valid);

endmodule

// File: tb/i2c_slave_dispatch_bench.sv
`timescale 1ns/1ps
module i2c_slave_dispatch_bench;
    localparam logic [6:0]  OWN  = 7'h51;
    localparam int unsigned TMS  = 5;
    localparam int unsigned CPMS = 4;
    localparam int          TMO  = TMS * CPMS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 0, evt_buserr = 0, evt_stop = 0, evt_nack = 0;
    logic evt_match = 0, evt_data = 0, evt_dir = 0, evt_own = 0, evt_gcall = 0;
    logic [7:0] evt_rx_byte = 0;
    logic usr_tx_valid = 0;
    logic [7:0] usr_tx_byte = 0;
    logic ev_valid, ctl_tx_valid;
    logic [2:0] ev_code;
    logic [7:0] ev_data, ctl_tx_byte;
    logic [1:0] slave_state;

    int n_checks = 0;
    int n_fail = 0;
    logic [1:0] ms;

    always #4 clk = ~clk;

    i2c_slave_dispatch #(.OWN_ADDR(OWN), .TIMEOUT_MS(TMS), .CYCLES_PER_MS(CPMS))
    u_i2c_slave_dispatch (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_buserr(evt_buserr),
        .evt_stop(evt_stop), .evt_nack(evt_nack), .evt_match(evt_match),
        .evt_data(evt_data), .evt_dir(evt_dir), .evt_own(evt_own),
        .evt_gcall(evt_gcall), .evt_rx_byte(evt_rx_byte),
        .usr_tx_valid(usr_tx_valid), .usr_tx_byte(usr_tx_byte),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_data(ev_data),
        .ctl_tx_valid(ctl_tx_valid), .ctl_tx_byte(ctl_tx_byte),
        .slave_state(slave_state)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected packed as {valid, code, data, state}
    function automatic logic [13:0] model(input logic [1:0] s, input logic be,
        input logic sp, input logic nk, input logic mt, input logic dt,
        input logic dr, input logic ow, input logic gc, input logic [7:0] rb);
        logic [13:0] m;
        if (ow) m = {1'b1, 3'd1, OWN, dr, dr ? 2'd1 : 2'd2};
        else if (gc) m = {1'b1, 3'd2, 8'h00, 2'd2};
        else m = {1'b1, 3'd7, 8'd2, 2'd0};
        if (be) return {1'b1, 3'd7, 8'd1, 2'd0};
        if (s == 2'd0) return mt ? m : {1'b0, 3'd0, 8'd0, 2'd0};
        if (sp) return {1'b1, 3'd6, 8'd0, 2'd0};
        if (nk && s == 2'd1) return {1'b1, 3'd5, 8'd0, 2'd1};
        if (mt) return m;
        if (dt) return (s == 2'd1) ? {1'b1, 3'd4, 8'd0, 2'd1} : {1'b1, 3'd3, rb, 2'd2};
        return {1'b1, 3'd7, 8'd2, 2'd0};
    endfunction

    function automatic string tag_of(input logic [2:0] c, input logic [7:0] d);
        case (c)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R9";
            3'd4: return "R9";
            3'd5: return "R8";
            3'd6: return "R7";
            3'd7: return (d == 8'd1) ? "R2" : "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic send(input logic be, input logic sp, input logic nk, input logic mt,
        input logic dt, input logic dr, input logic ow, input logic gc, input logic [7:0] rb);
        logic [13:0] e;
        e = model(ms, be, sp, nk, mt, dt, dr, ow, gc, rb);
        evt_valid = 1; evt_buserr = be; evt_stop = sp; evt_nack = nk; evt_match = mt;
        evt_data = dt; evt_dir = dr; evt_own = ow; evt_gcall = gc; evt_rx_byte = rb;
        @(negedge clk);
        evt_valid = 0; evt_buserr = 0; evt_stop = 0; evt_nack = 0; evt_match = 0;
        evt_data = 0; evt_dir = 0; evt_own = 0; evt_gcall = 0;
        chk({ev_valid, ev_code, ev_data, slave_state} == e,
            (ms != 2'd0 && mt && !be && !sp) ? "R6" : tag_of(e[12:10], e[9:2]),
            {18'd0, ev_valid, ev_code, ev_data, slave_state}, {18'd0, e});
        ms = e[1:0];
    endtask

    initial begin : watchdog
        #1500000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int first;
        void'($urandom(32'h5EED1));
        ms = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(slave_state == 0 && !ev_valid && !ctl_tx_valid, "R1",
            {ev_valid, ctl_tx_valid, slave_state}, 0);

        // R10: stop / data while idle are ignored
        send(0, 1, 0, 0, 1, 0, 0, 0, 8'h11);
        // R3: own match read, R12 forwarding in STX
        send(0, 0, 0, 1, 0, 1, 1, 0, 8'h00);
        usr_tx_valid = 1; usr_tx_byte = 8'hA5;
        @(negedge clk); usr_tx_valid = 0;
        chk(ctl_tx_valid && ctl_tx_byte == 8'hA5, "R12", {ctl_tx_valid, ctl_tx_byte}, 9'h1A5);
        send(0, 0, 1, 0, 1, 0, 0, 0, 8'h00);  // R8 nack kept
        send(0, 0, 0, 0, 1, 0, 0, 0, 8'h00);  // R9 tx request
        send(0, 1, 1, 1, 1, 0, 1, 0, 8'h00);  // R7 stop outranks
        // R4 own and gcall both: own wins; then gcall only
        send(0, 0, 0, 1, 0, 0, 1, 1, 8'h00);
        send(0, 0, 0, 1, 0, 1, 0, 1, 8'h00);
        // R12: offered while receiving is dropped
        usr_tx_valid = 1; usr_tx_byte = 8'h3C;
        @(negedge clk); usr_tx_valid = 0;
        chk(!ctl_tx_valid, "R12", ctl_tx_valid, 0);
        send(0, 0, 1, 0, 1, 0, 0, 0, 8'h77);  // R8 nack ignored in rx, R9 byte
        send(0, 0, 0, 1, 0, 1, 1, 0, 8'h00);  // R6 repeated start to tx
        send(0, 0, 0, 0, 0, 0, 0, 0, 8'h00);  // R9 no flags -> status error
        send(0, 0, 0, 1, 0, 0, 0, 0, 8'h00);  // R5 neither match kind
        send(0, 0, 0, 1, 0, 0, 1, 0, 8'h00);
        send(1, 1, 0, 1, 1, 0, 1, 0, 8'h00);  // R2 bus error outranks

        // R11 timeout from entry
        send(0, 0, 0, 1, 0, 0, 1, 0, 8'h00);
        first = 0;
        for (int j = 1; j <= TMO + 2; j++) begin
            @(negedge clk);
            if (ev_valid && first == 0) begin
                first = j;
                chk(ev_code == 3'd7 && ev_data == 8'd3 && slave_state == 0, "R11",
                    {ev_code, ev_data, slave_state}, {3'd7, 8'd3, 2'd0});
            end
        end
        chk(first == TMO, "R11", first, TMO);
        ms = 2'd0;
        // R11 restart on a byte
        send(0, 0, 0, 1, 0, 0, 1, 0, 8'h00);
        repeat (TMO - 5) @(negedge clk);
        send(0, 0, 0, 0, 1, 0, 0, 0, 8'h42);
        first = 0;
        for (int j = 1; j <= TMO + 2; j++) begin
            @(negedge clk);
            if (ev_valid && first == 0) first = j;
        end
        chk(first == TMO, "R11", first, TMO);
        ms = 2'd0;

        // random mix
        for (int i = 0; i < 500; i++) begin
            int gap;
            send(($urandom % 16) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
                 ($urandom % 3) == 0, ($urandom % 2) == 0, $urandom % 2,
                 ($urandom % 3) != 0, ($urandom % 2) == 0, 8'($urandom));
            gap = $urandom % 3;
            for (int g = 0; g < gap; g++) begin
                logic tv;
                logic [7:0] tb;
                tv = $urandom % 2; tb = 8'($urandom);
                usr_tx_valid = tv; usr_tx_byte = tb;
                @(negedge clk);
                usr_tx_valid = 0;
                chk(!ev_valid, "R10", ev_valid, 0);
                chk(ctl_tx_valid == (tv && ms == 2'd1) &&
                    (!ctl_tx_valid || ctl_tx_byte == tb), "R12",
                    {ctl_tx_valid, ctl_tx_byte}, {(tv && ms == 2'd1), tb});
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule